// File: doc/BRIEF.md
# Serial Port Interrupt Register Bank

This block keeps the interrupt bookkeeping for a serial port with four interrupt sources. Each source has a pending bit in a status word and a mask bit in an enable word. It drives its own level interrupt line, which is high while the source is both pending and enabled. The serial datapath reports hardware events as one-cycle pulses on `src_evt_i`, and each pulse marks the matching source pending. Software clears pending bits by writing ones to the status word. Software can also raise any source on purpose by writing to a write-only injection word, which is useful for exercising interrupt handlers without real traffic.

Access is through a simple word-addressed register port with separate write and read strobes. Read data is combinational and valid in the same cycle as the read strobe. The interrupt lines are registered, so each line follows its pending and enable bits one cycle late.

Top module: `uart_irq_bank`

## Requirements
- R1: Source bit positions are fixed in every word and on `src_evt_i` and `irq_o`: bit 0 transmit watermark, bit 1 receive watermark, bit 2 transmit empty, bit 3 receive overflow. A pulse on `src_evt_i[i]` sets pending bit i.
- R2: `irq_o[i]` is high exactly when pending bit i and enable bit i were both set in the previous cycle.
- R3: A write to byte offset 0x0 clears every pending bit whose `reg_wdata_i` bit is one and leaves the other pending bits unchanged.
- R4: A write to byte offset 0x8 ORs the low `reg_wdata_i` bits into the pending bits.
- R5: A read of offset 0x8, or of any offset other than 0x0 and 0x4, returns zero. `reg_rdata_o` is zero whenever `reg_rd_i` is low.
- R6: After reset all pending bits, enable bits and interrupt lines are zero.
- R7: A write to offset 0x4 loads the enable bits with the low `reg_wdata_i` bits, replacing the old value. A read of 0x4 returns them.
- R8: If a hardware event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: A read of offset 0x0 returns the current pending bits in the low bits, with the upper bits zero. `reg_wdata_i` bits above the source count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | N_SRC | One-cycle hardware event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the word |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, same cycle as the read strobe |
| irq_o | output | N_SRC | Per-source level interrupt lines |

## Verification
The bench uses the defaults: four sources, 32-bit data and a 4-bit address. With only four sources, every one of the 256 combinations of pending pattern and enable pattern can be injected and checked against the interrupt lines. The 4-bit address covers one unmapped word (0xC), and the 32-bit data word has idle upper bits, so the bench can show that both have no effect. Event pulses are also made to collide with clears of the same bit.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // Word indices (byte offset >> 2)
  localparam int unsigned WIDX_PEND   = 0;
  localparam int unsigned WIDX_ENABLE = 1;
  localparam int unsigned WIDX_INJECT = 2;

  typedef enum logic [1:0] {
    SRC_TX_WMARK = 2'd0,
    SRC_RX_WMARK = 2'd1,
    SRC_TX_EMPTY = 2'd2,
    SRC_RX_OVFL  = 2'd3
  } irq_src_e;

  // Pending bit update: sets (hardware or injected) dominate the clear.
  function automatic logic pend_next(input logic cur, input logic hw_set,
                                     input logic inj_set, input logic clr);
    return hw_set | inj_set | (cur & ~clr);
  endfunction

  // Interrupt level for one source.
  function automatic logic irq_level(input logic pend, input logic en);
    return pend & en;
  endfunction
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_pend_o,
  output logic              wr_enable_o,
  output logic              wr_inject_o,
  output logic              rd_pend_o,
  output logic              rd_enable_o
);
  import uart_irq_pkg::*;
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] widx;
  logic hit_pend, hit_enable, hit_inject;

  assign widx       = addr_i[ADDR_W-1:2];
  assign hit_pend   = (widx == WORD_W'(WIDX_PEND));
  assign hit_enable = (widx == WORD_W'(WIDX_ENABLE));
  assign hit_inject = (widx == WORD_W'(WIDX_INJECT));

  assign wr_pend_o   = wr_i & hit_pend;
  assign wr_enable_o = wr_i & hit_enable;
  assign wr_inject_o = wr_i & hit_inject;
  assign rd_pend_o   = rd_i & hit_pend;
  assign rd_enable_o = rd_i & hit_enable;
endmodule

// File: rtl/irq_src_slice.sv
module irq_src_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_evt_i,
  input  logic clr_i,
  input  logic inj_i,
  input  logic en_load_i,
  input  logic en_d_i,
  output logic pend_q_o,
  output logic en_q_o,
  output logic irq_q_o
);
  import uart_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q_o <= 1'b0;
      en_q_o   <= 1'b0;
      irq_q_o  <= 1'b0;
    end else begin
      pend_q_o <= pend_next(pend_q_o, hw_evt_i, inj_i, clr_i);
      if (en_load_i) en_q_o <= en_d_i;
      irq_q_o  <= irq_level(pend_q_o, en_q_o);
    end
  end
endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_SRC-1:0]  irq_o
);
  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic wr_pend, wr_enable, wr_inject, rd_pend, rd_enable;
  logic [N_SRC-1:0] wbits;
  logic [N_SRC-1:0] clr_mask;
  logic [N_SRC-1:0] inj_mask;
  logic [N_SRC-1:0] pend_vec;
  logic [N_SRC-1:0] enable_vec;
  logic [N_SRC-1:0] irq_vec;

  irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wr_pend_o   (wr_pend),
    .wr_enable_o (wr_enable),
    .wr_inject_o (wr_inject),
    .rd_pend_o   (rd_pend),
    .rd_enable_o (rd_enable)
  );

  assign wbits    = reg_wdata_i[N_SRC-1:0];
  assign clr_mask = wr_pend   ? wbits : '0;
  assign inj_mask = wr_inject ? wbits : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_src_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_evt_i  (src_evt_i[i]),
      .clr_i     (clr_mask[i]),
      .inj_i     (inj_mask[i]),
      .en_load_i (wr_enable),
      .en_d_i    (wbits[i]),
      .pend_q_o  (pend_vec[i]),
      .en_q_o    (enable_vec[i]),
      .irq_q_o   (irq_vec[i])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (rd_pend)        reg_rdata_o = {{PAD_W{1'b0}}, pend_vec};
    else if (rd_enable) reg_rdata_o = {{PAD_W{1'b0}}, enable_vec};
  end

  assign irq_o = irq_vec;
endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  src_evt,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [N_SRC-1:0]  irq,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  en_q
);
  logic a_pend, a_enable, a_inject;
  assign a_pend   = (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(0));
  assign a_enable = (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign a_inject = (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));

  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt))); // R8

  AST_INJECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && a_inject) |=> ((pend_q & $past(reg_wdata[N_SRC-1:0])) == $past(reg_wdata[N_SRC-1:0]))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && a_pend) |=> ((pend_q & $past(reg_wdata[N_SRC-1:0]) & ~$past(src_evt)) == '0)); // R3

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && a_enable) |=> (en_q == $past(reg_wdata[N_SRC-1:0]))); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(en_q)) == '0)); // R2

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(pend_q)) == '0)); // R2

  AST_INJECT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && a_inject) |-> (reg_rdata == '0)); // R5

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd) |-> (reg_rdata == '0)); // R5
endmodule

bind uart_irq_bank irq_bank_checker #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_irq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_evt   (src_evt_i),
  .reg_wr    (reg_wr_i),
  .reg_rd    (reg_rd_i),
  .reg_addr  (reg_addr_i),
  .reg_wdata (reg_wdata_i),
  .reg_rdata (reg_rdata_o),
  .irq       (irq_o),
  .pend_q    (pend_vec),
  .en_q      (enable_vec)
);

// File: tb/uart_irq_bank_bench.sv
module uart_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // Behavioural reference state
  int m_pend = 0, m_en = 0, m_irq = 0;

  always #2 clk = ~clk; // 250 MHz

  uart_irq_bank u_uart_irq_bank (
    .clk(clk), .rst_n(rst_n), .src_evt_i(evt), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // Reference model: interrupt = last cycle's (pending AND enabled);
  // pending = (old minus cleared) plus events plus injections.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_en = 0; m_irq = 0;
    end else begin
      int clr, inj, np;
      clr = (wr && addr == 4'h0) ? int'(wdata[3:0]) : 0;
      inj = (wr && addr == 4'h8) ? int'(wdata[3:0]) : 0;
      m_irq = m_pend & m_en;
      np = m_pend;
      for (int b = 0; b < 4; b++)
        if ((clr >> b) & 1) np = np & ~(1 << b);
      np = np | int'(evt) | inj;
      m_pend = np;
      if (wr && addr == 4'h4) m_en = int'(wdata[3:0]);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Per-clock comparison of interrupt lines (R2 / R1 bit order)
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) check("R2", int'(irq), m_irq);
  end

  task automatic drive(input logic [3:0] e, input logic w, input logic r,
                       input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    evt = e; wr = w; rd = r; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive('0, 0, 0, 4'h0, '0);
  endtask

  task automatic rd_chk(input logic [3:0] a, input int exp, input string req);
    drive('0, 0, 1, a, '0);
    #0.5;
    check(req, int'(rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6", int'(irq), 0);
    rst_n = 1'b1;
    idle(1);
    rd_chk(4'h0, 0, "R6");
    rd_chk(4'h4, 0, "R6");
    check("R5", int'(rdata & 0), 0);
    drive('0, 0, 0, 4'h0, '0);
    #0.5 check("R5", int'(rdata), 0);

    // R1: each event bit sets its own pending bit, in fixed order
    for (int s = 0; s < 4; s++) begin
      drive(4'(1 << s), 0, 0, 4'h0, '0);
      idle(1);
      rd_chk(4'h0, 1 << s, "R1");
      drive('0, 1, 0, 4'h0, 32'hF);
    end

    // Full sweep of pending x enable patterns (R2, R4, R7, R3)
    for (int en = 0; en < 16; en++) begin
      for (int st = 0; st < 16; st++) begin
        drive('0, 1, 0, 4'h0, 32'hF);            // clear all (R3)
        drive('0, 1, 0, 4'h4, 32'(en));          // load enable (R7)
        drive('0, 1, 0, 4'h8, 32'(st));          // inject (R4)
        idle(2);
        rd_chk(4'h0, st, "R4");
        rd_chk(4'h4, en, "R7");
      end
    end

    // R3: partial clear leaves other bits
    drive('0, 1, 0, 4'h8, 32'hF);
    drive('0, 1, 0, 4'h0, 32'h5);
    idle(1);
    rd_chk(4'h0, 'hA, "R3");

    // R8: event collides with clear of the same bit
    drive(4'h2, 1, 0, 4'h0, 32'hF);
    idle(1);
    rd_chk(4'h0, 'h2, "R8");

    // R9: upper write bits ignored, upper read bits zero
    drive('0, 1, 0, 4'h4, 32'hFFFF_FFF0);
    idle(1);
    rd_chk(4'h4, 0, "R9");
    drive('0, 1, 0, 4'h8, 32'hFFFF_FFF9);
    idle(1);
    rd_chk(4'h0, 'hB, "R9");

    // R5: inject and unmapped offsets read as zero
    rd_chk(4'h8, 0, "R5");
    rd_chk(4'hC, 0, "R5");
    drive('0, 1, 0, 4'hC, 32'hF);               // unmapped write: no effect
    idle(1);
    rd_chk(4'h4, 0, "R5");
    rd_chk(4'h0, 'hB, "R5");

    // R2 latency with enable change
    drive('0, 1, 0, 4'h4, 32'hF);
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule